// File: doc/BRIEF.md
# Decoder-Selected Row Array Rotator

This block rotates an 8-bit word to the right by any distance from 0 to 7 places in a single combinational path. It does not use a chain of log-distance stages. Instead it is a rectangular array of rows, and each row can rotate by one of two neighbouring distances. Row r covers the distances 2r and 2r+1.

The upper bits of the rotation amount drive a binary decoder that turns on exactly one row. The lowest amount bit is shared by every row and chooses between the row's even and odd distance. Each row first takes the input already rotated by 2r places, so that its one-place shifter only adds the final 0 or 1 place. A row that is switched off drives all zeros. The result is therefore the bitwise OR of all row outputs.

Each row is made of narrow one-place shifter segments. The bit that leaves one segment at its top comes from the lowest bit of the segment above it, and the top segment wraps around to the bottom one.

Top module: `row_array_rotator`

## Requirements
- R1: For every input value and every amount r in 0..7, data_out bit i equals data_in bit (i+r) mod 8.
- R2: With amount 0, data_out equals data_in.
- R3: amount[2:1] enables exactly one row. Row r is enabled when amount[2:1] equals r, and row r produces the distance 2r or 2r+1.
- R4: Every row that is not enabled outputs all zeros, so the OR merge carries only the enabled row.
- R5: amount[0]=1 gives the output for distance 2r rotated right by one more place.
- R6: The number of ones in data_out equals the number of ones in data_in.
- R7: Rotating by k and then by (8-k) mod 8 gives back the original value.
- R8: When data_in has only bit 0 set and k>0, data_out has only bit 8-k set. This shows the wrap across segment and word boundaries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_in | input | 8 | Word to rotate |
| amount | input | 3 | Right rotation distance, 0 to 7 |
| data_out | output | 8 | Rotated word |

## Verification
The hardest fault to expose from the ports is a disabled row that leaks ones into the OR merge. Such a leak is hidden whenever its bits coincide with the bits of the enabled row. The stimulus therefore uses single-bit and sparse words at every amount, where any extra one shows up as a wrong bit count or a wrong position. It also sweeps all 256 input values at every distance, which covers the carries between segments and the wrap from the top segment to the bottom one.

// File: rtl/row_array_rotator.sv
module row_array_rotator #(
  parameter int WIDTH = 8,
  parameter int SEG_W = 4
) (
  input  logic [WIDTH-1:0]         data_in,
  input  logic [$clog2(WIDTH)-1:0] amount,
  output logic [WIDTH-1:0]         data_out
);
  localparam int AMT_W = $clog2(WIDTH);
  localparam int SEL_W = AMT_W - 1;
  localparam int ROWS  = 1 << SEL_W;
  localparam int SEGS  = WIDTH / SEG_W;

  logic [ROWS-1:0]             row_en;
  logic [ROWS-1:0][WIDTH-1:0]  pre;
  logic [ROWS-1:0][WIDTH-1:0]  row_out;
  logic [ROWS:0][WIDTH-1:0]    merge;

  assign merge[0] = '0;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_en[r] = (amount[AMT_W-1:1] == SEL_W'(r));

    // fixed pre-rotation by 2r places, pure wiring
    for (genvar i = 0; i < WIDTH; i++) begin : g_pre
      assign pre[r][i] = data_in[(i + 2*r) % WIDTH];
    end

    // one-place shifter built from SEG_W-bit segments; top input of a
    // segment is the low bit of the next segment (wrapping at the top)
    for (genvar k = 0; k < SEGS; k++) begin : g_seg
      for (genvar j = 0; j < SEG_W; j++) begin : g_bit
        localparam int G   = k*SEG_W + j;
        localparam int NXT = (G + 1) % WIDTH;
        assign row_out[r][G] = row_en[r] & (amount[0] ? pre[r][NXT] : pre[r][G]);
      end
    end

    assign merge[r+1] = merge[r] | row_out[r];
  end

  assign data_out = merge[ROWS];
endmodule

module row_array_rotator_chk #(
  parameter int WIDTH = 8,
  parameter int AMT_W = 3,
  parameter int ROWS  = 4
) (
  input logic [WIDTH-1:0]            data_in,
  input logic [AMT_W-1:0]            amount,
  input logic [WIDTH-1:0]            data_out,
  input logic [ROWS-1:0]             row_en,
  input logic [ROWS-1:0][WIDTH-1:0]  row_out
);
  logic [2*WIDTH-1:0] dbl;
  assign dbl = {data_in, data_in} >> amount;

  always_comb begin
    a_r1_rotation: assert (data_out == dbl[WIDTH-1:0])
      else $error("R1 rotation mismatch");
    if (amount == '0)
      a_r2_identity: assert (data_out == data_in) else $error("R2 identity");
    a_r3_one_row: assert ($countones(row_en) == 1) else $error("R3 row enable");
    a_r3_row_sel: assert (row_en[amount[AMT_W-1:1]]) else $error("R3 wrong row");
    for (int r = 0; r < ROWS; r++)
      if (!row_en[r])
        a_r4_idle_zero: assert (row_out[r] == '0) else $error("R4 idle row leaks");
    a_r6_popcount: assert ($countones(data_out) == $countones(data_in))
      else $error("R6 popcount");
  end
endmodule

bind row_array_rotator row_array_rotator_chk #(
  .WIDTH(WIDTH), .AMT_W(AMT_W), .ROWS(ROWS)
) chk (
  .data_in(data_in), .amount(amount), .data_out(data_out),
  .row_en(row_en), .row_out(row_out)
);

// File: tb/row_array_rotator_test.sv
module row_array_rotator_test;
  logic       clk = 1'b0;
  logic [7:0] data_in;
  logic [2:0] amount;
  logic [7:0] data_out;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  row_array_rotator uut (.data_in(data_in), .amount(amount), .data_out(data_out));

  function automatic logic [7:0] ref_rot(input logic [7:0] v, input int r);
    logic [7:0] res;
    for (int i = 0; i < 8; i++) res[i] = v[(i + r) % 8];
    return res;
  endfunction

  task automatic apply(input logic [7:0] v, input int r);
    @(negedge clk);
    data_in = v;
    amount  = 3'(r);
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (in %h amt %0d)", req, act, exp, data_in, amount);
    end
  endtask

  task automatic test_zero_word();
    for (int r = 0; r < 8; r++) begin
      apply(8'h00, r);
      check("R4", data_out, 8'h00);
    end
  endtask

  task automatic test_identity();
    foreach (data_in[k]) ;
    for (int v = 0; v < 256; v += 17) begin
      apply(8'(v), 0);
      check("R2", data_out, 8'(v));
    end
  endtask

  task automatic test_exhaustive();
    for (int r = 0; r < 8; r++)
      for (int v = 0; v < 256; v++) begin
        apply(8'(v), r);
        check("R1", data_out, ref_rot(8'(v), r));
      end
  endtask

  task automatic test_walking_one();
    for (int k = 1; k < 8; k++) begin
      apply(8'h01, k);
      check("R8", data_out, 8'(1 << (8 - k)));
    end
  endtask

  task automatic test_sparse_rows();
    for (int r = 0; r < 8; r++)
      for (int b = 0; b < 8; b++) begin
        apply(8'(1 << b), r);
        checks++;
        if ($countones(data_out) != 1) begin
          fails++;
          $display("FAIL R3/R4: actual %h expected one bit set (b %0d r %0d)", data_out, b, r);
        end
      end
  endtask

  task automatic test_odd_step();
    logic [7:0] even_out;
    for (int r = 0; r < 4; r++) begin
      apply(8'hB4, 2*r);
      even_out = data_out;
      apply(8'hB4, 2*r + 1);
      check("R5", data_out, ref_rot(even_out, 1));
    end
  endtask

  task automatic test_popcount();
    for (int r = 0; r < 8; r++) begin
      apply(8'h6D, r);
      checks++;
      if ($countones(data_out) != 5) begin
        fails++;
        $display("FAIL R6: actual %0d expected 5", $countones(data_out));
      end
    end
  endtask

  task automatic test_inverse();
    logic [7:0] mid;
    for (int k = 0; k < 8; k++) begin
      apply(8'hC3 ^ 8'(k), k);
      mid = data_out;
      apply(mid, (8 - k) % 8);
      check("R7", data_out, 8'hC3 ^ 8'(k));
    end
  endtask

  initial begin
    data_in = '0;
    amount  = '0;
    test_zero_word();
    test_identity();
    test_exhaustive();
    test_walking_one();
    test_sparse_rows();
    test_odd_step();
    test_popcount();
    test_inverse();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule